// File: doc/BRIEF.md
# Indexed Configuration Space Controller

This block is the configuration front end of a multi-function I/O controller. A host reaches it over a byte-wide I/O bus through two ports. It writes a register index to the index port, then reads or writes the data port, and the access lands on the register that the index names. The index port sits at one of two addresses, chosen by a strap input. The data port is always at the next address.

The register space holds a global part and a banked part. The global part is a fixed identity byte, a chip configuration byte whose bit 0 enables the chip, and a logical-unit select. The banked part is one bank per logical unit, picked by the unit select. Each bank holds an activate byte and a 16-bit runtime base address. The GPIO unit also holds a pin select and, for each of 32 pins, a configuration byte and an event byte. The GPIO unit's base address and its combined enable go out as registered outputs, for the runtime register block to use when it decodes its own accesses.

Top module: `cfg_space_ctrl`

## Requirements
- R1: The index port is at 0x2E when `strap_alt_i` is 0 and at 0x4E when it is 1. The data port is the index port address + 1. A strobe at any other address changes no register and produces no `rvalid_o`.
- R2: The index register reads back from the index port. It keeps its value through any number of data-port accesses until the index port is written again.
- R3: Index 0x20 always reads 0xE9. Writes to it are ignored.
- R4: Index 0x21 is a read/write configuration byte with reset value 0x01. While its bit 0 is 0, `gpio_en_o` is 0.
- R5: Index 0x07 is the read/write logical-unit select, with reset value 0x00.
- R6: Index 0x30 is the activate byte of the selected unit, and each unit keeps its own. The GPIO unit (unit 7) resets to 0x01 and all other units reset to 0x00.
- R7: Index 0x60 is the high byte and index 0x61 is the low byte of the selected unit's 16-bit base address, and each unit keeps its own. The GPIO unit's base resets to parameter `GPIO_BASE_RST` (default 0x0680) and the other units reset to 0.
- R8: `gpio_base_o` carries the GPIO unit's base address. `gpio_en_o` is (configuration bit 0) AND (GPIO activate is nonzero). Both are registered and show a data write two clock edges after the write strobe.
- R9: Index 0xF0 is the pin select, and it is written only while unit 7 is selected. Pin n is encoded as ((n<<1)&0xF0)|(n&7), so bits 5:4 carry the port and bits 2:0 carry the bit. A read returns the stored select with bits 7, 6 and 3 cleared.
- R10: Indices 0xF1 and 0xF2 access the configuration byte and the event byte of the selected pin. There are 32 independent pins and all bytes reset to 0. When the selected unit is not 7, indices 0xF0 to 0xF2 read 0 and ignore writes.
- R11: An index outside the implemented set reads 0x00 and ignores writes. A unit number of `NUM_UNITS` (16) or more reads 0 at its banked indices and ignores writes to them.
- R12: A read strobe at either port gives `rvalid_o` = 1 with the data on `rdata_o` after the next clock edge, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_alt_i | input | 1 | Chooses the alternate index port address |
| addr_i | input | ADDR_W (16) | I/O address of the strobe |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while rvalid_o is high |
| rvalid_o | output | 1 | Read data valid, one cycle after the read strobe |
| gpio_base_o | output | 16 | GPIO unit runtime base address |
| gpio_en_o | output | 1 | GPIO runtime enable |

## Verification
Read data is due one clock edge after the read strobe. The driver puts each expected byte into a queue while the strobe is applied. The monitor takes items off that queue only on the falling edges where `rvalid_o` is high, so each result is compared in the cycle it is due, and any extra or missing result is flagged. `gpio_base_o` and `gpio_en_o` pass through two registers after a data write, so the bench samples them on the second falling edge after the write strobe. Every input is driven on a falling edge, half a cycle away from the capturing edge.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  localparam logic [7:0] IDX_UNIT_SEL = 8'h07;
  localparam logic [7:0] IDX_CHIP_ID  = 8'h20;
  localparam logic [7:0] IDX_CHIP_CFG = 8'h21;
  localparam logic [7:0] IDX_ACT      = 8'h30;
  localparam logic [7:0] IDX_BASE_HI  = 8'h60;
  localparam logic [7:0] IDX_BASE_LO  = 8'h61;
  localparam logic [7:0] IDX_PIN_SEL  = 8'hF0;
  localparam logic [7:0] IDX_PIN_CFG  = 8'hF1;
  localparam logic [7:0] IDX_PIN_EVT  = 8'hF2;
  localparam logic [7:0] CHIP_ID_VAL  = 8'hE9;
  localparam logic [7:0] CHIP_CFG_RST = 8'h01;
  localparam int unsigned PIN_SEL_W   = 5;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_IDX,
    ACC_DATA
  } acc_port_e;
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
  import cfg_space_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] PRI_ADDR = 'h2E,
  parameter logic [ADDR_W-1:0] ALT_ADDR = 'h4E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_alt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        idx_o,
  output logic              idx_rd_o,
  output logic              data_wr_o,
  output logic              data_rd_o
);
  logic [ADDR_W-1:0] idx_addr, data_addr;
  acc_port_e         port;
  logic [7:0]        idx_q;

  assign idx_addr  = strap_alt_i ? ALT_ADDR : PRI_ADDR;
  assign data_addr = idx_addr + ADDR_W'(1);

  always_comb begin
    if (addr_i == idx_addr)       port = ACC_IDX;
    else if (addr_i == data_addr) port = ACC_DATA;
    else                          port = ACC_NONE;
  end

  assign idx_rd_o  = rd_en_i && (port == ACC_IDX);
  assign data_rd_o = rd_en_i && (port == ACC_DATA);
  assign data_wr_o = wr_en_i && (port == ACC_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             idx_q <= '0;
    else if (wr_en_i && (port == ACC_IDX))   idx_q <= wdata_i;
  end

  assign idx_o = idx_q;

  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_o || data_rd_o) |=> $stable(idx_q)); // R2
endmodule

// File: rtl/cfg_unit_bank.sv
module cfg_unit_bank
  import cfg_space_pkg::*;
#(
  parameter int unsigned NUM_UNITS     = 16,
  parameter int unsigned GPIO_UNIT     = 7,
  parameter logic [15:0] GPIO_BASE_RST = 16'h0680
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  unit_i,
  input  logic [7:0]  idx_i,
  input  logic        wr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        hit_o,
  output logic [7:0]  gpio_act_o,
  output logic [15:0] gpio_base_o
);
  localparam int unsigned UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;

  logic [7:0]  act_q  [NUM_UNITS];
  logic [15:0] base_q [NUM_UNITS];
  logic              unit_ok;
  logic [UNIT_W-1:0] u;
  logic              is_act, is_hi, is_lo;

  assign unit_ok = (32'(unit_i) < NUM_UNITS);
  assign u       = UNIT_W'(unit_i);
  assign is_act  = (idx_i == IDX_ACT);
  assign is_hi   = (idx_i == IDX_BASE_HI);
  assign is_lo   = (idx_i == IDX_BASE_LO);
  assign hit_o   = unit_ok && (is_act || is_hi || is_lo);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_UNITS; k++) begin
        act_q[k]  <= (k == GPIO_UNIT) ? 8'h01 : 8'h00;
        base_q[k] <= (k == GPIO_UNIT) ? GPIO_BASE_RST : 16'h0000;
      end
    end else if (wr_i && unit_ok) begin
      if (is_act) act_q[u]        <= wdata_i;
      if (is_hi)  base_q[u][15:8] <= wdata_i;
      if (is_lo)  base_q[u][7:0]  <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (unit_ok) begin
      if (is_act)     rdata_o = act_q[u];
      else if (is_hi) rdata_o = base_q[u][15:8];
      else if (is_lo) rdata_o = base_q[u][7:0];
    end
  end

  assign gpio_act_o  = act_q[GPIO_UNIT];
  assign gpio_base_o = base_q[GPIO_UNIT];

  AST_BASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(gpio_base_o)); // R7
  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(gpio_act_o)); // R6
endmodule

// File: rtl/cfg_pin_store.sv
module cfg_pin_store
  import cfg_space_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [7:0]           idx_i,
  input  logic                 wr_i,
  input  logic [7:0]           wdata_i,
  input  logic [PIN_SEL_W-1:0] sel_wdata_i,
  output logic [7:0]           rdata_o,
  output logic                 hit_o
);
  logic [PIN_SEL_W-1:0] pin_q;
  logic [NUM_PINS*8-1:0] cfg_flat, evt_flat;
  logic pin_ok, is_sel, is_cfg, is_evt;

  assign is_sel = (idx_i == IDX_PIN_SEL);
  assign is_cfg = (idx_i == IDX_PIN_CFG);
  assign is_evt = (idx_i == IDX_PIN_EVT);
  assign hit_o  = en_i && (is_sel || is_cfg || is_evt);
  assign pin_ok = (32'(pin_q) < NUM_PINS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pin_q <= '0;
    else if (wr_i && en_i && is_sel) pin_q <= sel_wdata_i;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [7:0] cfg_q, evt_q;
    logic       here;
    assign here = en_i && wr_i && (32'(pin_q) == p);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q <= 8'h00;
        evt_q <= 8'h00;
      end else if (here) begin
        if (is_cfg) cfg_q <= wdata_i;
        if (is_evt) evt_q <= wdata_i;
      end
    end
    assign cfg_flat[p*8 +: 8] = cfg_q;
    assign evt_flat[p*8 +: 8] = evt_q;
  end

  always_comb begin
    rdata_o = 8'h00;
    if (en_i) begin
      if (is_sel)                rdata_o = {2'b00, pin_q[4:3], 1'b0, pin_q[2:0]};
      else if (is_cfg && pin_ok) rdata_o = cfg_flat[32'(pin_q)*8 +: 8];
      else if (is_evt && pin_ok) rdata_o = evt_flat[32'(pin_q)*8 +: 8];
    end
  end

  AST_SEL_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && en_i) |=> $stable(pin_q)); // R10
endmodule

// File: rtl/cfg_space_ctrl.sv
module cfg_space_ctrl
  import cfg_space_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned NUM_UNITS     = 16,
  parameter int unsigned NUM_PINS      = 32,
  parameter int unsigned GPIO_UNIT     = 7,
  parameter logic [15:0] GPIO_BASE_RST = 16'h0680
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_alt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  output logic [15:0]       gpio_base_o,
  output logic              gpio_en_o
);
  logic [7:0]  idx;
  logic        idx_rd, data_wr, data_rd;
  logic [7:0]  chip_cfg_q, unit_sel_q;
  logic [7:0]  bank_rdata, pin_rdata, rd_val;
  logic        bank_hit, pin_hit, gpio_sel, known;
  logic [7:0]  gpio_act;
  logic [15:0] gpio_base;

  cfg_port_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i, .rst_ni, .strap_alt_i, .addr_i, .wr_en_i, .rd_en_i, .wdata_i,
    .idx_o(idx), .idx_rd_o(idx_rd), .data_wr_o(data_wr), .data_rd_o(data_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chip_cfg_q <= CHIP_CFG_RST;
      unit_sel_q <= 8'h00;
    end else if (data_wr) begin
      if (idx == IDX_CHIP_CFG) chip_cfg_q <= wdata_i;
      if (idx == IDX_UNIT_SEL) unit_sel_q <= wdata_i;
    end
  end

  cfg_unit_bank #(
    .NUM_UNITS(NUM_UNITS), .GPIO_UNIT(GPIO_UNIT), .GPIO_BASE_RST(GPIO_BASE_RST)
  ) u_bank (
    .clk_i, .rst_ni, .unit_i(unit_sel_q), .idx_i(idx), .wr_i(data_wr),
    .wdata_i, .rdata_o(bank_rdata), .hit_o(bank_hit),
    .gpio_act_o(gpio_act), .gpio_base_o(gpio_base)
  );

  assign gpio_sel = (32'(unit_sel_q) == GPIO_UNIT);

  cfg_pin_store #(.NUM_PINS(NUM_PINS)) u_pins (
    .clk_i, .rst_ni, .en_i(gpio_sel), .idx_i(idx), .wr_i(data_wr),
    .wdata_i, .sel_wdata_i({wdata_i[5:4], wdata_i[2:0]}),
    .rdata_o(pin_rdata), .hit_o(pin_hit)
  );

  always_comb begin
    known  = 1'b1;
    rd_val = 8'h00;
    if (idx_rd)                    rd_val = idx;
    else if (idx == IDX_CHIP_ID)   rd_val = CHIP_ID_VAL;
    else if (idx == IDX_CHIP_CFG)  rd_val = chip_cfg_q;
    else if (idx == IDX_UNIT_SEL)  rd_val = unit_sel_q;
    else if (bank_hit)             rd_val = bank_rdata;
    else if (pin_hit)              rd_val = pin_rdata;
    else                           known  = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o     <= 8'h00;
      rvalid_o    <= 1'b0;
      gpio_base_o <= GPIO_BASE_RST;
      gpio_en_o   <= 1'b1;
    end else begin
      rvalid_o    <= idx_rd || data_rd;
      if (idx_rd || data_rd) rdata_o <= rd_val;
      gpio_base_o <= gpio_base;
      gpio_en_o   <= chip_cfg_q[0] && (gpio_act != 8'h00);
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_rd || data_rd) |=> rvalid_o); // R12
  AST_NO_STRAY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(idx_rd || data_rd) |=> !rvalid_o); // R1
  AST_ID_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && idx == IDX_CHIP_ID) |=> (rdata_o == CHIP_ID_VAL)); // R3
  AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !known) |=> (rdata_o == 8'h00)); // R11
  AST_EN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_cfg_q[0] |=> !gpio_en_o); // R4
endmodule

// File: tb/cfg_space_ctrl_test.sv
`timescale 1ns/1ps
module cfg_space_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strap_alt_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        rvalid_o;
  logic [15:0] gpio_base_o;
  logic        gpio_en_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_val[$];
  string      exp_tag[$];
  logic [15:0] ia = 16'h002E, da = 16'h002F;

  always #2.5 clk = ~clk;

  cfg_space_ctrl uut (
    .clk_i(clk), .rst_ni, .strap_alt_i, .addr_i, .wr_en_i, .rd_en_i,
    .wdata_i, .rdata_o, .rvalid_o, .gpio_base_o, .gpio_en_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge.
  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    addr_i = a; rd_en_i = 1'b1;
    exp_val.push_back(e); exp_tag.push_back(tag);
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    bus_wr(ia, i); bus_wr(da, d);
  endtask

  task automatic reg_rd(input logic [7:0] i, input logic [7:0] e, input string tag);
    bus_wr(ia, i); bus_rd(da, e, tag);
  endtask

  task automatic settle;  // outputs registered twice after a write
    @(negedge clk);
  endtask

  // Monitor: compare each read result in the cycle it is due.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && rvalid_o) begin
        if (exp_val.size() == 0) begin
          checks++; errors++;
          $display("FAIL R12 actual rvalid with data %0h expected no result", rdata_o);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_val.pop_front();
          t = exp_tag.pop_front();
          chk(t, rdata_o, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R12 reset rvalid", rvalid_o, 0);
    chk("R12 reset rdata", rdata_o, 8'h00);
    chk("R8 reset gpio_en", gpio_en_o, 1);
    chk("R7 reset gpio_base", gpio_base_o, 16'h0680);

    // R3 identity byte and write-ignore
    reg_rd(8'h20, 8'hE9, "R3 id read");
    bus_wr(da, 8'h55);
    bus_rd(da, 8'hE9, "R3 id after write");
    bus_rd(da, 8'hE9, "R2 index held on repeat read");
    bus_rd(ia, 8'h20, "R2 index readback");

    // R4 chip config
    reg_rd(8'h21, 8'h01, "R4 cfg reset");
    bus_wr(da, 8'h00); settle();
    chk("R4 gpio_en off by cfg", gpio_en_o, 0);
    bus_rd(da, 8'h00, "R4 cfg readback");
    bus_wr(da, 8'h01); settle();
    chk("R8 gpio_en back on", gpio_en_o, 1);

    // R5 unit select, R7 base
    reg_rd(8'h07, 8'h00, "R5 unit sel reset");
    bus_wr(da, 8'h07);
    bus_rd(da, 8'h07, "R5 unit sel readback");
    reg_rd(8'h30, 8'h01, "R6 gpio act reset");
    reg_rd(8'h60, 8'h06, "R7 gpio base hi reset");
    reg_wr(8'h60, 8'h12);
    reg_wr(8'h61, 8'h34); settle();
    chk("R8 gpio_base follows", gpio_base_o, 16'h1234);
    bus_rd(da, 8'h34, "R7 base lo readback");

    // R6/R7 banking
    reg_wr(8'h07, 8'h0D);
    reg_rd(8'h60, 8'h00, "R7 unit D base reset");
    bus_wr(da, 8'hAB);
    bus_rd(da, 8'hAB, "R7 unit D base readback");
    reg_rd(8'h30, 8'h00, "R6 unit D act reset");
    bus_wr(da, 8'h05); settle();
    chk("R7 gpio_base unaffected by unit D", gpio_base_o, 16'h1234);
    reg_wr(8'h07, 8'h07);
    reg_rd(8'h60, 8'h12, "R7 gpio base kept");
    reg_wr(8'h30, 8'h00); settle();
    chk("R6 gpio_en off by activate", gpio_en_o, 0);
    reg_wr(8'h30, 8'h01); settle();
    chk("R6 gpio_en on by activate", gpio_en_o, 1);

    // R9/R10 pins: pin13 -> 0x15, pin5 -> 0x05, pin31 -> 0x37
    reg_wr(8'hF0, 8'h15); reg_wr(8'hF1, 8'hA5); reg_wr(8'hF2, 8'h3C);
    reg_wr(8'hF0, 8'h05); reg_wr(8'hF1, 8'h11);
    reg_rd(8'hF2, 8'h00, "R10 pin5 event untouched");
    reg_wr(8'hF0, 8'h15);
    reg_rd(8'hF1, 8'hA5, "R10 pin13 cfg");
    reg_rd(8'hF2, 8'h3C, "R10 pin13 event");
    reg_wr(8'hF0, 8'h37); reg_wr(8'hF1, 8'h77);
    reg_wr(8'hF0, 8'h15);
    reg_rd(8'hF1, 8'hA5, "R10 pin13 kept after pin31");
    reg_wr(8'hF0, 8'hFF);
    bus_rd(da, 8'h37, "R9 select masked");
    reg_rd(8'hF1, 8'h77, "R9 0xFF maps to pin31");

    // R10 pin regs gated by unit select
    reg_wr(8'h07, 8'h0D);
    reg_rd(8'hF1, 8'h00, "R10 pin cfg hidden");
    bus_wr(da, 8'h99);
    reg_wr(8'hF0, 8'h05);
    reg_rd(8'hF0, 8'h00, "R10 pin select hidden");
    reg_wr(8'h07, 8'h07);
    reg_rd(8'hF0, 8'h37, "R10 select not written while hidden");
    reg_rd(8'hF1, 8'h77, "R10 cfg not written while hidden");

    // R11 unimplemented index and out-of-range unit
    reg_rd(8'h55, 8'h00, "R11 unimpl read");
    bus_wr(da, 8'hFF);
    bus_rd(da, 8'h00, "R11 unimpl after write");
    reg_wr(8'h07, 8'h20);
    reg_wr(8'h30, 8'h01);
    reg_rd(8'h30, 8'h00, "R11 big unit act");
    reg_wr(8'h07, 8'h07);

    // R1 alternate address ignored when strap is 0
    bus_wr(ia, 8'h21);
    bus_wr(16'h004E, 8'h20);
    addr_i = 16'h004E; rd_en_i = 1'b1; @(negedge clk); rd_en_i = 1'b0;
    chk("R1 no rvalid at off address", rvalid_o, 0);
    bus_rd(ia, 8'h21, "R1 index unchanged by off address");

    // R1 strap selects alternate pair
    strap_alt_i = 1'b1; ia = 16'h004E; da = 16'h004F;
    bus_rd(ia, 8'h21, "R1 alt index port");
    reg_rd(8'h20, 8'hE9, "R1 alt data port");
    bus_wr(16'h002E, 8'h07);
    bus_rd(ia, 8'h20, "R1 primary ignored under strap");

    repeat (3) @(negedge clk);
    chk("R12 all reads returned", exp_val.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule